// File: doc/BRIEF.md
# Latched Register Write Bridge

This block connects an asynchronous, byte-wide processor write port to a small bank of registers that live in the system clock domain. The processor's combined write strobe is active when both chip select and write enable are low. This strobe is passed through a two-stage synchroniser. While it is active, the address and data are captured into a holding latch. The latched value is committed to the addressed register a fixed number of system clocks after the processor releases the strobe.

A fast processor learns that a commit has finished in one of two ways. It can poll a toggle bit, which inverts once per committed write. It can also watch a busy output. A write whose synchronised strobe arrives while the previous commit is still pending is discarded, and this is recorded in a sticky overrun flag. A read port returns the committed contents of the register at the presented address. It also returns a value that was committed on the edge just before.

The processor must hold its strobe active for at least three system clocks. It must keep address and data stable while the strobe is active and for one clock after releasing it.

Top module: `latched_wr_bridge`

## Requirements
- R1: With rst high at a clock edge, all registers, the toggle bit, busy, overrun and the read data are zero after that edge.
- R2: A write stores into the register at cpu_addr the data held on cpu_wdata when the strobe is released. A value changed partway through an active strobe is overridden by the later stable value.
- R3: Edge 1 is the first rising edge at which the synchroniser samples the released strobe. The register contents and the toggle bit change at edge 4, and not before.
- R4: The toggle bit inverts exactly once for every committed write to an in-range register. It never changes at any other time outside reset.
- R5: Busy is low after the first rising edge that samples a newly active strobe and high after the second. It stays high through edge 3 of R3 and is low after edge 4 when no new strobe has started.
- R6: A write to an address of NUM_REGS or above changes no register and leaves the toggle bit unchanged. A read of such an address returns zero.
- R7: A strobe whose synchronised assertion first appears while a commit is pending sets overrun and has its write dropped, while the pending commit still completes. Overrun stays set until reset.
- R8: cpu_rdata shows the register at cpu_addr one clock after the address is sampled. This includes a value committed on that same edge, so a readback right after the commit needs no extra wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_cs_n | input | 1 | Processor chip select, active low |
| cpu_wr_n | input | 1 | Processor write enable, active low |
| cpu_addr | input | ADDR_W | Register address for write and read |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Registered readback of the addressed register |
| busy | output | 1 | High from strobe detection until the commit |
| toggle | output | 1 | Inverts once per committed in-range write |
| overrun | output | 1 | Sticky flag: a write was dropped while a commit was pending |

## Verification
The bench uses several kinds of write. Isolated writes with different hold lengths and data values separate correct addressing and data storage from timing errors. A write whose data changes partway through the strobe shows whether the latch keeps the final value or the first one. A write to an out-of-range address separates proper address decode from a silent wrap onto a real register. A second strobe raised one clock after release lands in the commit window, and shows whether the pending write survives while the intruder is dropped. A scoreboard compares each toggle flip with the exact clock at which it should occur, which catches early, late, missing and extra commits.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_HOLD   = 2'd1,
    PH_SETTLE = 2'd2,
    PH_SHED   = 2'd3
  } wb_phase_t;
endpackage

// File: rtl/wb_sync.sv
module wb_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d,
  output logic [STAGES-1:0] taps
);
  always_ff @(posedge clk) begin
    if (rst) taps <= '0;
    else     taps <= {taps[STAGES-2:0], d};
  end
endmodule

// File: rtl/wb_latch_ctl.sv
module wb_latch_ctl
  import wb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              early,
  input  logic              synced,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              commit_en,
  output logic [ADDR_W-1:0] hold_addr,
  output logic [DATA_W-1:0] hold_data,
  output logic              busy,
  output logic              overrun
);
  wb_phase_t phase, phase_nx;
  logic      capture;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:   if (synced)  phase_nx = PH_HOLD;
      PH_HOLD:   if (!synced) phase_nx = PH_SETTLE;
      PH_SETTLE: phase_nx = synced ? PH_SHED : PH_IDLE;
      PH_SHED:   if (!synced) phase_nx = PH_IDLE;
      default:   phase_nx = PH_IDLE;
    endcase
  end

  // latch follows the bus only while an accepted strobe is seen on both stages
  assign capture   = early && synced && (phase == PH_IDLE || phase == PH_HOLD);
  assign commit_en = (phase == PH_SETTLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      hold_addr <= '0;
      hold_data <= '0;
      busy      <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      phase <= phase_nx;
      if (capture) begin
        hold_addr <= bus_addr;
        hold_data <= bus_data;
      end
      busy <= early || (phase_nx != PH_IDLE);
      if (phase == PH_SETTLE && synced) overrun <= 1'b1;
    end
  end
endmodule

// File: rtl/wb_regbank.sv
module wb_regbank #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              toggle
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] bank [NUM_REGS];
  logic              hit, rd_ok;

  assign hit   = we && ({1'b0, waddr} < LIMIT);
  assign rd_ok = ({1'b0, raddr} < LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
      rdata  <= '0;
      toggle <= 1'b0;
    end else begin
      if (hit) begin
        bank[waddr] <= wdata;
        toggle      <= ~toggle;
      end
      // write-through so a same-edge commit is visible at once
      if (!rd_ok)                  rdata <= '0;
      else if (hit && raddr == waddr) rdata <= wdata;
      else                         rdata <= bank[raddr];
    end
  end
endmodule

// File: rtl/latched_wr_bridge.sv
module latched_wr_bridge #(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int NUM_REGS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_cs_n,
  input  logic              cpu_wr_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              busy,
  output logic              toggle,
  output logic              overrun
);
  localparam int LAST_TAP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] taps;
  logic                   strobe_raw, commit_en;
  logic [ADDR_W-1:0]      hold_addr;
  logic [DATA_W-1:0]      hold_data;

  assign strobe_raw = !cpu_cs_n && !cpu_wr_n;

  wb_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(strobe_raw), .taps(taps)
  );

  wb_latch_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctl_i (
    .clk(clk), .rst(rst),
    .early(taps[0]), .synced(taps[LAST_TAP]),
    .bus_addr(cpu_addr), .bus_data(cpu_wdata),
    .commit_en(commit_en), .hold_addr(hold_addr), .hold_data(hold_data),
    .busy(busy), .overrun(overrun)
  );

  wb_regbank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) bank_i (
    .clk(clk), .rst(rst),
    .we(commit_en), .waddr(hold_addr), .wdata(hold_data),
    .raddr(cpu_addr), .rdata(cpu_rdata), .toggle(toggle)
  );
endmodule

// File: rtl/latched_wr_bridge_chk.sv
module latched_wr_bridge_chk #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_cs_n,
  input logic              cpu_wr_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              busy,
  input logic              toggle,
  input logic              overrun
);
  logic armed = 1'b0;
  logic rst_q = 1'b0;
  logic strobe;

  assign strobe = !cpu_cs_n && !cpu_wr_n;

  always_ff @(posedge clk) begin
    armed <= !rst;
    rst_q <= rst;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst_q |-> (!busy && !toggle && !overrun));

  // R4
  toggle_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    (toggle != $past(toggle)) |-> $past(busy));

  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(overrun) |-> overrun);

  // R6
  out_of_range_read_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ({1'b0, $past(cpu_addr)} >= (ADDR_W+1)'(NUM_REGS)) |-> (cpu_rdata == '0));

  // R5
  busy_on_strobe_chk: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(strobe) && strobe) |=> busy);
endmodule

bind latched_wr_bridge latched_wr_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) chk_i (
  .clk(clk), .rst(rst), .cpu_cs_n(cpu_cs_n), .cpu_wr_n(cpu_wr_n),
  .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
  .busy(busy), .toggle(toggle), .overrun(overrun)
);

// File: tb/latched_wr_bridge_test.sv
module latched_wr_bridge_test;
  localparam int ADDR_W = 4, DATA_W = 8, NUM_REGS = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1, cs_n = 1'b1, wr_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              busy, toggle, overrun;

  latched_wr_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) uut (
    .clk(clk), .rst(rst), .cpu_cs_n(cs_n), .cpu_wr_n(wr_n),
    .cpu_addr(addr), .cpu_wdata(wdata), .cpu_rdata(rdata),
    .busy(busy), .toggle(toggle), .overrun(overrun)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int exp_q[$];
  logic [DATA_W-1:0] model [NUM_REGS];
  logic last_t = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: full write with busy/timing checks; pushes expected commit cycle
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d0,
                    input logic [DATA_W-1:0] d1, input int hold);
    logic t0;
    @(negedge clk);
    t0 = toggle;
    addr = a; wdata = d0; cs_n = 1'b0; wr_n = 1'b0;
    tick(1);
    check(!busy, "R5 busy before sync", busy, 0);
    tick(1);
    check(busy, "R5 busy after sync", busy, 1);
    wdata = d1;
    tick(hold - 2);
    cs_n = 1'b1; wr_n = 1'b1;
    if (a < NUM_REGS) begin
      exp_q.push_back(cyc + 4);
      model[a] = d1;
    end
    tick(3);
    check(busy, "R5 busy held to commit", busy, 1);
    check(toggle == t0, "R3 no early commit", toggle, t0);
    tick(1);
    check(!busy, "R5 busy clear after commit", busy, 0);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string req);
    addr = a;
    tick(1);
    check(rdata == e, req, rdata, e);
  endtask

  // monitor: each toggle flip must match the next expected commit cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst) last_t = toggle;
      else if (toggle !== last_t) begin
        last_t = toggle;
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected toggle", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R3 R4 commit cycle", cyc, e);
        end
      end
    end
  end

  initial begin
    #400000;
    check(1'b0, "watchdog", cyc, 0);
    report();
  end

  initial begin
    for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
    tick(4);
    check(!busy && !toggle && !overrun, "R1 reset outputs", {busy, toggle, overrun}, 0);
    rst = 1'b0;
    tick(1);
    rd(0, 0, "R1 reg0 zero");
    rd(11, 0, "R1 reg11 zero");

    wr(3, 8'hA5, 8'hA5, 4);
    rd(3, 8'hA5, "R8 R2 immediate readback");
    wr(0, 8'h3C, 8'h3C, 6);
    wr(11, 8'hFF, 8'hFF, 3);
    wr(7, 8'h01, 8'h01, 8);
    rd(0, 8'h3C, "R2 reg0");
    rd(11, 8'hFF, "R2 reg11");
    rd(7, 8'h01, "R2 reg7");

    // data changed mid-strobe: final value must win
    wr(5, 8'h11, 8'h77, 6);
    rd(5, 8'h77, "R2 late data wins");

    // out-of-range write
    begin
      logic t0;
      t0 = toggle;
      wr(13, 8'h99, 8'h99, 4);
      tick(2);
      check(toggle == t0, "R6 toggle unchanged", toggle, t0);
      rd(13, 0, "R6 read out of range");
      for (int i = 0; i < NUM_REGS; i++) rd(i[ADDR_W-1:0], model[i], "R6 bank untouched");
    end

    // overrun: second strobe one clock after release
    check(!overrun, "R7 overrun clear", overrun, 0);
    @(negedge clk);
    addr = 2; wdata = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
    tick(4);
    cs_n = 1'b1; wr_n = 1'b1;
    exp_q.push_back(cyc + 4);
    model[2] = 8'h5A;
    tick(1);
    addr = 9; wdata = 8'hC3; cs_n = 1'b0; wr_n = 1'b0;
    tick(5);
    cs_n = 1'b1; wr_n = 1'b1;
    tick(6);
    check(overrun, "R7 overrun set", overrun, 1);
    rd(9, model[9], "R7 dropped write");
    rd(2, 8'h5A, "R7 pending write kept");
    wr(4, 8'h42, 8'h42, 4);
    rd(4, 8'h42, "R7 later write accepted");
    check(overrun, "R7 overrun sticky", overrun, 1);
    check(exp_q.size() == 0, "R4 all commits seen", exp_q.size(), 0);

    // reset after activity
    @(negedge clk);
    rst = 1'b1;
    tick(2);
    check(!busy && !toggle && !overrun, "R1 reset clears flags", {busy, toggle, overrun}, 0);
    rst = 1'b0;
    tick(1);
    rd(2, 0, "R1 reg2 cleared");
    rd(3, 0, "R1 reg3 cleared");
    tick(2);
    report();
  end
endmodule